// File: doc/BRIEF.md
# Latched 4-to-16 Decoder / Demultiplexer

This block turns a four-bit select address into a sixteen-line one-hot bus. A transparent address latch sits in front of the decoder. While the latch is open, the outputs follow the address directly. While it is closed, the decoded line stays fixed and changes on the select pins have no effect. An active-low enable skips the latch and gates the output bus directly. This lets one enable line act as a chip select when several blocks are cascaded.

The same block also works as a one-to-sixteen demultiplexer. In that use, the enable pin carries the data bit and the select pins carry the destination. The output polarity is fixed when the block is built. One variant drives the chosen line high and idles low. The other drives the chosen line low and idles high.

Top module: `latched_decoder16`

## Requirements
- R1: With the enable low and the latch open, the binary value n on `sel_addr` (bit 3 most significant) asserts output line n, for every n from 0 to 15.
- R2: While `addr_open` is 1, the decoded line follows every change on `sel_addr` with no clock involved.
- R3: While `addr_open` is 0, the outputs keep the line chosen by the address present when `addr_open` fell, and changes on `sel_addr` leave the outputs unchanged.
- R4: With `enable_n` at 0, exactly one output line is at its active level.
- R5: With `enable_n` at 1, every output line sits at its inactive level whatever the address: all 0 when ACTIVE_LOW=0, all 1 when ACTIVE_LOW=1.
- R6: ACTIVE_LOW=0 drives the selected line to 1 and the others to 0. ACTIVE_LOW=1 drives the selected line to 0 and the others to 1, so its bus is the bitwise inverse of the ACTIVE_LOW=0 bus for the same inputs.
- R7: Used as a demultiplexer, the addressed line carries the inverse of `enable_n` when ACTIVE_LOW=0 and carries `enable_n` unchanged when ACTIVE_LOW=1. All other lines stay inactive.
- R8: `enable_n` is not latched. It gates the outputs at once even while `addr_open` is 0, and the held address survives the gating.
- R9: Reopening the latch after a hold picks up the address now on `sel_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel_addr | input | 4 | Binary select address; bit 3 is most significant |
| addr_open | input | 1 | 1 makes the address latch transparent; 0 holds it |
| enable_n | input | 1 | Active-low output enable; the data input in demultiplexer use |
| line_out | output | 16 | Decoded one-hot bus with the polarity set by ACTIVE_LOW |

## Verification
The assertions are immediate checks on combinational values. They assume every input is driven to a known 0 or 1, and they assume the latch has been opened at least once before its contents matter. The bench meets both conditions: it drives all three inputs to defined levels at time zero, it opens the latch before it reads any decoded line, and it changes inputs only on the falling clock edge, so each check sees settled values. Both polarity variants get the same stimulus side by side, which lets one variant be compared bit for bit against the inverse of the other.

// File: rtl/ldec_pkg.sv
package ldec_pkg;
  parameter int unsigned SEL_W_DEF = 4;

  function automatic logic idle_level(input bit active_low);
    return active_low ? 1'b1 : 1'b0;
  endfunction
endpackage

// File: rtl/ldec_addr_hold.sv
module ldec_addr_hold #(
  parameter int unsigned SEL_W = 4
) (
  input  logic [SEL_W-1:0] d_in,
  input  logic             open_i,
  output logic [SEL_W-1:0] q_out
);
  always_latch begin
    if (open_i) q_out = d_in;
  end
endmodule

// File: rtl/ldec_onehot.sv
module ldec_onehot #(
  parameter int unsigned SEL_W = 4,
  localparam int unsigned LINES = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] code_i,
  output logic [LINES-1:0] hot_o
);
  for (genvar k = 0; k < LINES; k++) begin : g_line
    assign hot_o[k] = (code_i == SEL_W'(k));
  end
endmodule

// File: rtl/ldec_drive.sv
module ldec_drive #(
  parameter int unsigned LINES      = 16,
  parameter bit          ACTIVE_LOW = 1'b0
) (
  input  logic [LINES-1:0] hot_i,
  input  logic             gate_n,
  output logic [LINES-1:0] bus_o
);
  logic [LINES-1:0] gated;

  assign gated = gate_n ? '0 : hot_i;

  if (ACTIVE_LOW) begin : g_low
    assign bus_o = ~gated;
  end else begin : g_high
    assign bus_o = gated;
  end
endmodule

// File: rtl/latched_decoder16.sv
module latched_decoder16 #(
  parameter int unsigned SEL_W      = ldec_pkg::SEL_W_DEF,
  parameter bit          ACTIVE_LOW = 1'b0,
  localparam int unsigned LINES     = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel_addr,
  input  logic             addr_open,
  input  logic             enable_n,
  output logic [LINES-1:0] line_out
);
  localparam logic IDLE = ldec_pkg::idle_level(ACTIVE_LOW);

  logic [SEL_W-1:0] held_addr;
  logic [LINES-1:0] hot_vec;
  logic [LINES-1:0] active_view;

  ldec_addr_hold #(.SEL_W(SEL_W)) u_hold (
    .d_in  (sel_addr),
    .open_i(addr_open),
    .q_out (held_addr)
  );

  ldec_onehot #(.SEL_W(SEL_W)) u_dec (
    .code_i(held_addr),
    .hot_o (hot_vec)
  );

  ldec_drive #(.LINES(LINES), .ACTIVE_LOW(ACTIVE_LOW)) u_drv (
    .hot_i (hot_vec),
    .gate_n(enable_n),
    .bus_o (line_out)
  );

  // Output bus seen as active-high, whatever the polarity
  assign active_view = ACTIVE_LOW ? ~line_out : line_out;

  always_comb begin
    // R4
    single_line_chk: assert (enable_n !== 1'b0 || $countones(active_view) == 1);
    // R5
    idle_bus_chk: assert (enable_n !== 1'b1 || line_out == {LINES{IDLE}});
    // R1
    addr_line_chk: assert (enable_n !== 1'b0 || active_view[held_addr] == 1'b1);
    // R2
    open_follow_chk: assert (addr_open !== 1'b1 || held_addr == sel_addr);
  end
endmodule

// File: tb/sim_latched_decoder16.sv
module sim_latched_decoder16;
  logic        clk = 1'b0;
  logic [3:0]  sel_addr = 4'd0;
  logic        addr_open = 1'b0;
  logic        enable_n = 1'b1;
  logic [15:0] y_hi;
  logic [15:0] y_lo;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  latched_decoder16 #(.ACTIVE_LOW(1'b0)) u0 (
    .sel_addr(sel_addr), .addr_open(addr_open), .enable_n(enable_n), .line_out(y_hi));
  latched_decoder16 #(.ACTIVE_LOW(1'b1)) u1 (
    .sel_addr(sel_addr), .addr_open(addr_open), .enable_n(enable_n), .line_out(y_lo));

  function automatic logic [15:0] expect_hi(input logic [3:0] a, input logic en_n);
    return en_n ? 16'h0000 : (16'h0001 << a);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] a, input logic le, input logic en_n);
    @(negedge clk);
    sel_addr = a; addr_open = le; enable_n = en_n;
    #1;
  endtask

  task automatic t_idle_start;
    apply(4'd7, 1'b1, 1'b1);
    chk("R5 idle hi", y_hi, 16'h0000);
    chk("R5 idle lo", y_lo, 16'hFFFF);
  endtask

  task automatic t_sweep;
    for (int n = 0; n < 16; n++) begin
      apply(4'(n), 1'b1, 1'b0);
      chk("R1 R2 R4 sweep hi", y_hi, expect_hi(4'(n), 1'b0));
      chk("R6 sweep lo", y_lo, ~expect_hi(4'(n), 1'b0));
    end
  endtask

  task automatic t_hold;
    apply(4'd5, 1'b1, 1'b0);
    apply(4'd5, 1'b0, 1'b0);
    apply(4'd9, 1'b0, 1'b0);
    chk("R3 hold hi", y_hi, expect_hi(4'd5, 1'b0));
    chk("R3 hold lo", y_lo, ~expect_hi(4'd5, 1'b0));
    apply(4'd14, 1'b0, 1'b0);
    chk("R3 hold second change", y_hi, expect_hi(4'd5, 1'b0));
  endtask

  task automatic t_gate_while_held;
    apply(4'd3, 1'b1, 1'b0);
    apply(4'd3, 1'b0, 1'b0);
    apply(4'd12, 1'b0, 1'b1);
    chk("R8 R5 gated hi", y_hi, 16'h0000);
    chk("R8 R5 gated lo", y_lo, 16'hFFFF);
    apply(4'd12, 1'b0, 1'b0);
    chk("R8 ungate keeps held hi", y_hi, expect_hi(4'd3, 1'b0));
    chk("R8 ungate keeps held lo", y_lo, ~expect_hi(4'd3, 1'b0));
  endtask

  task automatic t_demux;
    logic [7:0] data = 8'b1011_0010;
    apply(4'd10, 1'b1, 1'b0);
    apply(4'd10, 1'b0, 1'b0);
    for (int b = 0; b < 8; b++) begin
      apply(4'd10, 1'b0, data[b]);
      chk("R7 demux hi line", {15'd0, y_hi[10]}, {15'd0, ~data[b]});
      chk("R7 demux lo line", {15'd0, y_lo[10]}, {15'd0, data[b]});
      chk("R7 demux others hi", y_hi & ~16'h0400, 16'h0000);
    end
  endtask

  task automatic t_reopen;
    apply(4'd2, 1'b1, 1'b0);
    apply(4'd2, 1'b0, 1'b0);
    apply(4'd13, 1'b0, 1'b0);
    chk("R9 before reopen", y_hi, expect_hi(4'd2, 1'b0));
    apply(4'd13, 1'b1, 1'b0);
    chk("R9 after reopen hi", y_hi, expect_hi(4'd13, 1'b0));
    chk("R6 inverse after reopen", y_lo, ~y_hi);
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_idle_start();
    t_sweep();
    t_hold();
    t_gate_while_held();
    t_demux();
    t_reopen();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule